// File: doc/BRIEF.md
# Branch Direction and Target Predictor

This block sits beside the fetch stage of a pipelined processor. Each cycle it looks up the current fetch address in two tables that share that address as their index source: a history table of two-bit saturating counters, which gives the likely direction, and a direct-mapped target cache, which gives the address a taken branch jumped to last time. When the counter leans taken and the target cache holds a matching entry, the block reports a taken prediction and hands back the cached target as the next fetch address in the same cycle, so a correctly predicted taken branch costs no bubble. Otherwise the next fetch address is the sequential one, four bytes on.

When a branch resolves later in the pipeline, the pipeline returns the branch address, the real outcome, the real target and the prediction that was made for it. The block trains the counter, records the target of a taken branch, and raises a flush together with the corrected fetch address when the earlier prediction was wrong. Each counter is a four-state machine. Its states are CTR_STRONG_NT (00), CTR_WEAK_NT (01), CTR_WEAK_T (10) and CTR_STRONG_T (11). Its transitions are "step up" on a taken outcome and "step down" on a not-taken outcome, and it holds at either end. Because a strong state survives one contrary outcome, a loop branch that exits once is mispredicted once and not again on re-entry.

Top module: `branch_predictor`

## Requirements
- R1: After reset every counter is CTR_WEAK_NT (01) and every target entry is invalid, so any fetch address predicts not taken with next address fetch_pc + 4.
- R2: A counter steps up by one state on a taken resolution and down by one on a not-taken resolution, and saturates at 00 and 11. The predicted direction is counter bit 1.
- R3: From CTR_STRONG_T, a single not-taken resolution leaves the prediction taken. Two consecutive not-taken resolutions are needed to turn it to not taken.
- R4: When the counter at the fetch index has bit 1 set and the target entry at the fetch index is valid with a matching tag, pred_taken is 1 and pred_next_pc equals the cached target in that same cycle.
- R5: If the counter has bit 1 clear, or the target entry is invalid or its tag differs, pred_taken is 0 and pred_next_pc is fetch_pc + 4.
- R6: A taken resolution writes the valid bit, tag and target into the target entry. A not-taken resolution leaves the target entry untouched.
- R7: In the resolution cycle, flush is 1 exactly when upd_taken differs from upd_pred_taken, or when both are 1 and upd_target differs from upd_pred_target. While flush is 1, flush_pc is upd_target for a taken branch and upd_pc + 4 for a not-taken one.
- R8: A lookup in the same cycle as an update at the same index sees the contents held before that update.
- R9: The history index is pc[7:2] (64 counters). The target index is pc[5:2] (16 entries), and its tag is pc[31:6]. Addresses 256 bytes apart share a counter and a target entry but carry different tags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| fetch_pc | input | 32 | Address being fetched this cycle |
| pred_taken | output | 1 | Predicted taken with a known target |
| pred_next_pc | output | 32 | Predicted next fetch address |
| upd_valid | input | 1 | A branch resolves this cycle |
| upd_pc | input | 32 | Address of the resolving branch |
| upd_taken | input | 1 | Actual outcome, 1 = taken |
| upd_target | input | 32 | Actual taken target |
| upd_pred_taken | input | 1 | Direction that was predicted for this branch |
| upd_pred_target | input | 32 | Next address that was predicted for this branch |
| flush | output | 1 | The prediction was wrong; redirect fetch |
| flush_pc | output | 32 | Corrected fetch address while flush is 1 |

## Verification
The hardest state to reach from the ports is a shared counter whose entry in the target cache belongs to another branch. In that state the direction says taken but the tag check must force a sequential prediction. The directed part trains one branch and then fetches an address 256 bytes away. The random part draws addresses from a small pool that holds such aliasing pairs, so counters pass through every state while the target entries are overwritten by their neighbours. The hysteresis walk, which saturates at both ends and survives a single loop exit, is driven directly on one address.

// File: rtl/bp_pkg.sv
package bp_pkg;

    typedef enum logic [1:0] {
        CTR_STRONG_NT = 2'b00,
        CTR_WEAK_NT   = 2'b01,
        CTR_WEAK_T    = 2'b10,
        CTR_STRONG_T  = 2'b11
    } ctr_state_t;

    localparam ctr_state_t CTR_RESET = CTR_WEAK_NT;

endpackage

// File: rtl/bp_history_table.sv
module bp_history_table
    import bp_pkg::*;
#(
    parameter int IDX_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] rd_idx,
    output logic             rd_taken,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic             wr_taken
);
    localparam int DEPTH = 1 << IDX_W;

    ctr_state_t ctr_q [DEPTH];
    ctr_state_t cur_state;
    ctr_state_t nxt_state;

    assign cur_state = ctr_q[wr_idx];

    // Next-state logic for the entry being trained.
    always_comb begin
        nxt_state = cur_state;
        unique case (cur_state)
            CTR_STRONG_NT: nxt_state = wr_taken ? CTR_WEAK_NT  : CTR_STRONG_NT;
            CTR_WEAK_NT:   nxt_state = wr_taken ? CTR_WEAK_T   : CTR_STRONG_NT;
            CTR_WEAK_T:    nxt_state = wr_taken ? CTR_STRONG_T : CTR_WEAK_NT;
            CTR_STRONG_T:  nxt_state = wr_taken ? CTR_STRONG_T : CTR_WEAK_T;
            default:       nxt_state = CTR_RESET;
        endcase
    end

    // State register array.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                ctr_q[i] <= CTR_RESET;
            end
        end else if (wr_en) begin
            ctr_q[wr_idx] <= nxt_state;
        end
    end

    // Output decode: direction from the upper counter bit.
    always_comb begin
        unique case (ctr_q[rd_idx])
            CTR_WEAK_T, CTR_STRONG_T:   rd_taken = 1'b1;
            CTR_STRONG_NT, CTR_WEAK_NT: rd_taken = 1'b0;
            default:                    rd_taken = 1'b0;
        endcase
    end

endmodule

// File: rtl/bp_target_cache.sv
module bp_target_cache #(
    parameter int PC_W  = 32,
    parameter int IDX_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [PC_W-1:0]  rd_pc,
    output logic             rd_hit,
    output logic [PC_W-1:0]  rd_target,
    input  logic             wr_en,
    input  logic [PC_W-1:0]  wr_pc,
    input  logic [PC_W-1:0]  wr_target
);
    localparam int DEPTH = 1 << IDX_W;
    localparam int LO    = 2;
    localparam int TAG_W = PC_W - IDX_W - LO;

    logic [DEPTH-1:0]  valid_q;
    logic [TAG_W-1:0]  tag_q    [DEPTH];
    logic [PC_W-1:0]   target_q [DEPTH];

    logic [IDX_W-1:0]  rd_idx;
    logic [IDX_W-1:0]  wr_idx;
    logic [TAG_W-1:0]  rd_tag;
    logic [TAG_W-1:0]  wr_tag;
    logic [2*LO-1:0]   unused_lo;

    assign rd_idx    = rd_pc[LO +: IDX_W];
    assign wr_idx    = wr_pc[LO +: IDX_W];
    assign rd_tag    = rd_pc[PC_W-1 -: TAG_W];
    assign wr_tag    = wr_pc[PC_W-1 -: TAG_W];
    assign unused_lo = {rd_pc[LO-1:0], wr_pc[LO-1:0]};

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= '0;
        end else if (wr_en) begin
            valid_q[wr_idx] <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en) begin
            tag_q[wr_idx]    <= wr_tag;
            target_q[wr_idx] <= wr_target;
        end
    end

    assign rd_hit    = valid_q[rd_idx] && (tag_q[rd_idx] == rd_tag);
    assign rd_target = target_q[rd_idx];

endmodule

// File: rtl/bp_resolve.sv
module bp_resolve #(
    parameter int PC_W = 32
) (
    input  logic            upd_valid,
    input  logic [PC_W-1:0] upd_pc,
    input  logic            upd_taken,
    input  logic [PC_W-1:0] upd_target,
    input  logic            upd_pred_taken,
    input  logic [PC_W-1:0] upd_pred_target,
    output logic            flush,
    output logic [PC_W-1:0] flush_pc
);
    logic dir_wrong;
    logic tgt_wrong;

    always_comb begin
        dir_wrong = upd_taken != upd_pred_taken;
        tgt_wrong = upd_taken && upd_pred_taken && (upd_target != upd_pred_target);
        flush     = upd_valid && (dir_wrong || tgt_wrong);
        flush_pc  = upd_taken ? upd_target : upd_pc + PC_W'(4);
    end

endmodule

// File: rtl/branch_predictor.sv
module branch_predictor #(
    parameter int PC_W      = 32,
    parameter int BHT_IDX_W = 6,
    parameter int BTB_IDX_W = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [PC_W-1:0] fetch_pc,
    output logic            pred_taken,
    output logic [PC_W-1:0] pred_next_pc,
    input  logic            upd_valid,
    input  logic [PC_W-1:0] upd_pc,
    input  logic            upd_taken,
    input  logic [PC_W-1:0] upd_target,
    input  logic            upd_pred_taken,
    input  logic [PC_W-1:0] upd_pred_target,
    output logic            flush,
    output logic [PC_W-1:0] flush_pc
);
    localparam int LO = 2;

    logic [BHT_IDX_W-1:0] hist_rd_idx;
    logic [BHT_IDX_W-1:0] hist_wr_idx;
    logic                 dir_taken;
    logic                 tgt_hit;
    logic [PC_W-1:0]      tgt_value;
    logic [PC_W-1:0]      seq_pc;

    assign hist_rd_idx = fetch_pc[LO +: BHT_IDX_W];
    assign hist_wr_idx = upd_pc[LO +: BHT_IDX_W];
    assign seq_pc      = fetch_pc + PC_W'(4);

    bp_history_table #(
        .IDX_W (BHT_IDX_W)
    ) u_hist (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_idx   (hist_rd_idx),
        .rd_taken (dir_taken),
        .wr_en    (upd_valid),
        .wr_idx   (hist_wr_idx),
        .wr_taken (upd_taken)
    );

    bp_target_cache #(
        .PC_W  (PC_W),
        .IDX_W (BTB_IDX_W)
    ) u_tgt (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_pc     (fetch_pc),
        .rd_hit    (tgt_hit),
        .rd_target (tgt_value),
        .wr_en     (upd_valid && upd_taken),
        .wr_pc     (upd_pc),
        .wr_target (upd_target)
    );

    bp_resolve #(
        .PC_W (PC_W)
    ) u_res (
        .upd_valid       (upd_valid),
        .upd_pc          (upd_pc),
        .upd_taken       (upd_taken),
        .upd_target      (upd_target),
        .upd_pred_taken  (upd_pred_taken),
        .upd_pred_target (upd_pred_target),
        .flush           (flush),
        .flush_pc        (flush_pc)
    );

    always_comb begin
        if (dir_taken && tgt_hit) begin
            pred_taken   = 1'b1;
            pred_next_pc = tgt_value;
        end else begin
            pred_taken   = 1'b0;
            pred_next_pc = seq_pc;
        end
    end

endmodule

// File: rtl/bp_checker.sv
module bp_checker #(
    parameter int PC_W = 32
) (
    input logic            clk,
    input logic            rst_n,
    input logic [PC_W-1:0] fetch_pc,
    input logic            pred_taken,
    input logic [PC_W-1:0] pred_next_pc,
    input logic            upd_valid,
    input logic [PC_W-1:0] upd_pc,
    input logic            upd_taken,
    input logic [PC_W-1:0] upd_target,
    input logic            upd_pred_taken,
    input logic            flush,
    input logic [PC_W-1:0] flush_pc
);
    AST_SEQ_WHEN_NOT_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
        !pred_taken |-> pred_next_pc == fetch_pc + PC_W'(4)); // R5

    AST_FLUSH_NEEDS_UPDATE: assert property (@(posedge clk) disable iff (!rst_n)
        flush |-> upd_valid); // R7

    AST_FLUSH_ON_DIR_MISS: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_valid && (upd_taken != upd_pred_taken)) |-> flush); // R7

    AST_FLUSH_PC_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
        (flush && upd_taken) |-> flush_pc == upd_target); // R7

    AST_FLUSH_PC_SEQ: assert property (@(posedge clk) disable iff (!rst_n)
        (flush && !upd_taken) |-> flush_pc == upd_pc + PC_W'(4)); // R7

    AST_FILL_VISIBLE: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_valid && upd_taken) |=>
        (fetch_pc != $past(upd_pc) || !pred_taken || pred_next_pc == $past(upd_target))); // R6

endmodule

bind branch_predictor bp_checker #(
    .PC_W (PC_W)
) u_bp_checker (
    .clk            (clk),
    .rst_n          (rst_n),
    .fetch_pc       (fetch_pc),
    .pred_taken     (pred_taken),
    .pred_next_pc   (pred_next_pc),
    .upd_valid      (upd_valid),
    .upd_pc         (upd_pc),
    .upd_taken      (upd_taken),
    .upd_target     (upd_target),
    .upd_pred_taken (upd_pred_taken),
    .flush          (flush),
    .flush_pc       (flush_pc)
);

// File: tb/tb_branch_predictor.sv
module tb_branch_predictor;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [31:0] fetch_pc;
    logic        pred_taken;
    logic [31:0] pred_next_pc;
    logic        upd_valid;
    logic [31:0] upd_pc;
    logic        upd_taken;
    logic [31:0] upd_target;
    logic        upd_pred_taken;
    logic [31:0] upd_pred_target;
    logic        flush;
    logic [31:0] flush_pc;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    // Reference state built from the requirements.
    int          m_ctr   [64];
    bit          m_valid [16];
    logic [25:0] m_tag   [16];
    logic [31:0] m_tgt   [16];

    always #2 clk = ~clk;

    branch_predictor dut (
        .clk             (clk),
        .rst_n           (rst_n),
        .fetch_pc        (fetch_pc),
        .pred_taken      (pred_taken),
        .pred_next_pc    (pred_next_pc),
        .upd_valid       (upd_valid),
        .upd_pc          (upd_pc),
        .upd_taken       (upd_taken),
        .upd_target      (upd_target),
        .upd_pred_taken  (upd_pred_taken),
        .upd_pred_target (upd_pred_target),
        .flush           (flush),
        .flush_pc        (flush_pc)
    );

    function automatic bit exp_taken(logic [31:0] pc);
        int hi = pc[7:2];
        int bi = pc[5:2];
        return (m_ctr[hi] >= 2) && m_valid[bi] && (m_tag[bi] == pc[31:6]);
    endfunction

    function automatic logic [31:0] exp_next(logic [31:0] pc);
        return exp_taken(pc) ? m_tgt[pc[5:2]] : pc + 32'd4;
    endfunction

    function automatic bit exp_flush(bit v, bit t, logic [31:0] tg, bit pt, logic [31:0] ptg);
        return v && ((t != pt) || (t && tg != ptg));
    endfunction

    task automatic model_reset();
        for (int i = 0; i < 64; i++) m_ctr[i] = 1;
        for (int i = 0; i < 16; i++) begin
            m_valid[i] = 0;
            m_tag[i]   = '0;
            m_tgt[i]   = '0;
        end
    endtask

    task automatic model_update(logic [31:0] pc, bit t, logic [31:0] tg);
        int hi = pc[7:2];
        int bi = pc[5:2];
        if (t && m_ctr[hi] < 3) m_ctr[hi]++;
        if (!t && m_ctr[hi] > 0) m_ctr[hi]--;
        if (t) begin
            m_valid[bi] = 1;
            m_tag[bi]   = pc[31:6];
            m_tgt[bi]   = tg;
        end
    endtask

    task automatic check1(string req, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // One cycle: drive at negedge, check before the edge, then let the edge train.
    task automatic cycle(string req, logic [31:0] fpc, bit v, logic [31:0] upc, bit t,
                         logic [31:0] tg, bit pt, logic [31:0] ptg);
        @(negedge clk);
        fetch_pc        = fpc;
        upd_valid       = v;
        upd_pc          = upc;
        upd_taken       = t;
        upd_target      = tg;
        upd_pred_taken  = pt;
        upd_pred_target = ptg;
        #1;
        check1(req, "pred_taken", 32'(pred_taken), 32'(exp_taken(fpc)));
        check1(req, "pred_next_pc", pred_next_pc, exp_next(fpc));
        check1(req, "flush", 32'(flush), 32'(exp_flush(v, t, tg, pt, ptg)));
        if (exp_flush(v, t, tg, pt, ptg))
            check1(req, "flush_pc", flush_pc, t ? tg : upc + 32'd4);
        if (v) model_update(upc, t, tg);
    endtask

    // Resolve a branch using the model's own prediction (no flush unless wrong).
    task automatic resolve(string req, logic [31:0] pc, bit t, logic [31:0] tg);
        cycle(req, pc, 1, pc, t, tg, exp_taken(pc), exp_next(pc));
    endtask

    task automatic look(string req, logic [31:0] pc);
        cycle(req, pc, 0, 32'h0, 0, 32'h0, 0, 32'h0);
    endtask

    task automatic expect_dir(string req, logic [31:0] pc, bit exp);
        look(req, pc);
        check1(req, "direction", 32'(pred_taken), 32'(exp));
    endtask

    initial begin
        logic [31:0] pool [8];
        logic [31:0] A;
        logic [31:0] TA;
        A  = 32'h0000_1040;
        TA = 32'h0000_2000;
        pool = '{32'h1040, 32'h1140, 32'h1044, 32'h1084,
                 32'h2040, 32'h1048, 32'h1148, 32'h30C0};
        void'($urandom(32'd1357));
        model_reset();
        rst_n = 0; fetch_pc = 0; upd_valid = 0; upd_pc = 0; upd_taken = 0;
        upd_target = 0; upd_pred_taken = 0; upd_pred_target = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1;

        // R1: reset state
        expect_dir("R1", A, 0);
        check1("R1", "seq next", pred_next_pc, A + 32'd4);
        expect_dir("R1", 32'hFFFF_FFFC, 0);

        // R8: update and lookup same index in one cycle -> lookup sees old state
        cycle("R8", A, 1, A, 1, TA, 0, A + 32'd4);
        check1("R8", "old pred", 32'(pred_taken), 32'd0);
        check1("R8", "flush on dir miss", 32'(flush), 32'd1);
        // R4 / R6: after the fill, hit with taken counter -> cached target
        expect_dir("R4", A, 1);
        check1("R4", "target", pred_next_pc, TA);

        // R2 / R3: walk counter to strong taken, then loop exit
        resolve("R2", A, 1, TA);
        resolve("R2", A, 1, TA);
        resolve("R3", A, 0, TA);
        check1("R3", "exit flush", 32'(flush), 32'd1);
        expect_dir("R3", A, 1);
        resolve("R3", A, 1, TA);
        check1("R3", "re-entry no flush", 32'(flush), 32'd0);
        resolve("R3", A, 0, TA);
        resolve("R3", A, 0, TA);
        expect_dir("R3", A, 0);
        // R6: not-taken outcomes left the target intact
        resolve("R6", A, 1, TA);
        expect_dir("R6", A, 1);
        check1("R6", "target kept", pred_next_pc, TA);
        // R2: saturate low then one step up stays not taken
        for (int i = 0; i < 5; i++) resolve("R2", A, 0, TA);
        resolve("R2", A, 1, TA);
        expect_dir("R2", A, 0);
        resolve("R2", A, 1, TA);
        expect_dir("R2", A, 1);

        // R9 / R5: alias 256 bytes away shares counter, tag mismatches
        expect_dir("R9", A + 32'd256, 0);
        check1("R5", "alias seq", pred_next_pc, A + 32'd260);
        // R7: target mismatch with correct direction
        cycle("R7", A, 1, A, 1, 32'h0000_3000, 1, TA);
        check1("R7", "tgt flush", 32'(flush), 32'd1);
        check1("R7", "tgt flush_pc", flush_pc, 32'h0000_3000);
        // R7: predicted taken, actually not taken
        cycle("R7", A, 1, A, 0, 32'h0, 1, 32'h0000_3000);
        check1("R7", "seq flush_pc", flush_pc, A + 32'd4);

        // Random mix: R2 R4 R5 R6 R7 R8 R9
        for (int n = 0; n < 3000; n++) begin
            logic [31:0] fp, up, tg, ptg;
            bit v, t, pt;
            fp = pool[$urandom_range(0, 7)];
            up = pool[$urandom_range(0, 7)];
            v  = ($urandom_range(0, 3) != 0);
            t  = ($urandom_range(0, 2) != 0);
            tg = 32'h0000_4000 + {24'h0, 6'($urandom_range(0, 3)), 2'b00};
            if ($urandom_range(0, 3) != 0) begin
                pt  = exp_taken(up);
                ptg = exp_next(up);
            end else begin
                pt  = 1'($urandom_range(0, 1));
                ptg = tg;
            end
            cycle("R7_rand", fp, v, up, t, tg, pt, ptg);
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule